// File: doc/BRIEF.md
# Converter Mode and Calibration Controller

This block sits between the serial register port of a delta-sigma output converter and its modulator. It keeps the command word and the data, offset and gain words. It sequences the converter through sleep, a short wake-up, normal running and self-calibration, and it turns every accepted data update into a code word for the modulator. Each code word goes out with a fast-settle flag.

The serial port presents one whole register word per write strobe. Address 0 selects the 16-bit data word, 1 the command word, 2 the 24-bit offset word and 3 the 24-bit gain word. The mode field in the command word works both ways. Software writes it to change mode, and reads it back to see whether calibration is still busy. While calibration runs, every register write is dropped. Calibration ends after a fixed number of clocks, or earlier when the external comparator reports completion. The result words supplied from outside are then captured.

The code stream to the modulator is valid/ready. A word is transferred on a cycle where both valid and ready are high. While valid is high and ready is low, the code and the flag hold still. Updates that arrive during a stall collapse into one word that carries the newest data. Nothing is lost except intermediate values.

Top module: `dac_mode_ctrl`

## Requirements
- R1: After reset the mode field reads 10 (sleep), and the data, offset, gain and other command bits read zero. The output is disabled, no code word is valid, and the reference code for step size is 0000h.
- R2: A command write whose mode field (bits 1:0) is 01 starts calibration on the next clock. While calibration runs, the field reads 01, busy is high and writes to every address are ignored. When calibration finishes, the field reads 00.
- R3: Calibration lasts CAL_CYC clocks, or ends on the first clock where the calibration-done input is high. On that clock the offset and gain words load the external offset and gain results unchanged.
- R4: A command write with bit 3 (clear) set zeroes the data word and launches a new code word. The clear bit reads back as 0.
- R5: A command write with bit 4 (calibration reset) set zeroes the offset and gain words. The bit reads back as 0.
- R6: The code word is the data word with its MSB inverted when format bit 2 is 0 (offset two's complement: 8000h minimum, 0000h midscale, 7FFFh maximum). When the bit is 1 (straight binary), the code word is the data word unchanged.
- R7: The fast-settle flag works in three steps. It is 0 when bit 5 (no-fast) is set. Otherwise it is 1 when bit 6 (always-fast) is set. Otherwise it is 1 only when the absolute difference from the previously launched code exceeds STEP_TH.
- R8: The output enable is 0 in sleep and during wake-up, and 1 in normal mode. During calibration it follows bit 7 (connect-during-calibration).
- R9: Leaving sleep for normal or calibration first spends PWR_CYC clocks in wake-up, with the power-up output high, before that mode begins.
- R10: A command write whose mode field is 11 leaves the mode and the sequencer unchanged, while the other command bits still take the written values.
- R11: A data write, or a clear, launches a code word one clock later if the stream is free. While valid is high and ready is low, the code and flag stay stable. Updates made during the stall are merged into one word that carries the latest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the serial port |
| wr_addr | input | 2 | Register select: 0 data, 1 command, 2 offset, 3 gain |
| wr_data | input | 24 | Write word (low bits used for 16-bit registers) |
| cal_done_i | input | 1 | Comparator reports calibration complete |
| cal_offs_i | input | 24 | Offset result of calibration |
| cal_gain_i | input | 24 | Gain result of calibration (unsigned) |
| cmd_o | output | 16 | Command word readback with live mode field |
| data_o | output | 16 | Data word readback |
| offs_o | output | 24 | Offset word readback |
| gain_o | output | 24 | Gain word readback |
| mod_valid_o | output | 1 | Code word valid to modulator |
| mod_ready_i | input | 1 | Modulator accepts code word |
| mod_code_o | output | 16 | Straight-binary code word |
| mod_fast_o | output | 1 | Fast-settle request for this code word |
| out_en_o | output | 1 | Output buffer connected |
| powering_o | output | 1 | Wake-up sequence in progress |
| cal_busy_o | output | 1 | Calibration in progress (mode field is 01) |

## Verification
The bench targets the mode lockout first. It writes data, offset, gain and command words while calibration runs. A design that still took them would change the readbacks or launch a stray code word. Both calibration endings are covered, the early done pulse and the full count, as well as a calibration started from sleep. A design that skipped wake-up, or loaded the results one clock late, would show the wrong mode or wrong offset and gain in the cycle the model expects.

For the stream, the bench holds ready low across several data writes. A design that let the code move during the stall, or kept the oldest value, would be caught. The step-size decision is checked just below and just above the threshold, and under each override bit. A reserved mode write is also tried; a design that took it would leave the sequencer in a mode it cannot leave.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2,
    ST_CAL   = 2'd3
  } seq_state_t;

  localparam logic [1:0] MODE_RUN   = 2'b00;
  localparam logic [1:0] MODE_CAL   = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;
  localparam logic [1:0] MODE_RSVD  = 2'b11;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_CMD  = 2'd1;
  localparam logic [1:0] ADR_OFFS = 2'd2;
  localparam logic [1:0] ADR_GAIN = 2'd3;

  localparam int B_FMT    = 2;
  localparam int B_CLR    = 3;
  localparam int B_CRST   = 4;
  localparam int B_NOFAST = 5;
  localparam int B_ALWAYS = 6;
  localparam int B_CALPIN = 7;

  typedef struct packed {
    logic cal_pin;
    logic always_fast;
    logic no_fast;
    logic fmt_bin;
  } ctl_t;
endpackage

// File: rtl/dmc_seq.sv
module dmc_seq
  import dmc_pkg::*;
#(
  parameter int CAL_CYC = 1000000,
  parameter int PWR_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_val,
  input  logic       cal_done_i,
  input  logic       cal_pin,
  output logic [1:0] mode_q,
  output logic       cal_load,
  output logic       out_en,
  output logic       powering
);
  localparam int MAXC = (CAL_CYC > PWR_CYC) ? CAL_CYC : PWR_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t      state;
  logic [CW-1:0]   cnt;
  logic            wake_end;

  assign wake_end = (cnt == CW'(PWR_CYC - 1));
  assign cal_load = (state == ST_CAL) &&
                    ((cnt == CW'(CAL_CYC - 1)) || cal_done_i);
  assign out_en   = (state == ST_RUN) || ((state == ST_CAL) && cal_pin);
  assign powering = (state == ST_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_SLEEP;
      mode_q <= MODE_SLEEP;
      cnt    <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_val;
      unique case (mode_val)
        MODE_SLEEP: state <= ST_SLEEP;
        MODE_RUN: begin
          if (state == ST_SLEEP) begin
            state <= ST_WAKE;
            cnt   <= '0;
          end else if (state != ST_WAKE) begin
            state <= ST_RUN;
          end
        end
        default: begin
          if (state == ST_SLEEP) begin
            state <= ST_WAKE;
            cnt   <= '0;
          end else if (state != ST_WAKE) begin
            state <= ST_CAL;
            cnt   <= '0;
          end
        end
      endcase
    end else begin
      unique case (state)
        ST_WAKE: begin
          if (wake_end) begin
            state <= (mode_q == MODE_CAL) ? ST_CAL : ST_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAL: begin
          if (cal_load) begin
            state  <= ST_RUN;
            mode_q <= MODE_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_cal_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL) |=> ((state == ST_CAL) || (state == ST_RUN && mode_q == MODE_RUN)));
  p_sleep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP || state == ST_WAKE) |-> !out_en);
  p_wake_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> (cnt < CW'(PWR_CYC)));
  p_no_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MODE_RSVD);
  p_cal_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL) |-> (mode_q == MODE_CAL));
endmodule

// File: rtl/dmc_regs.sv
module dmc_regs
  import dmc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CALW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  logic [1:0]      wr_addr,
  input  logic [CALW-1:0] wr_data,
  input  logic            cal_load,
  input  logic [CALW-1:0] cal_offs_i,
  input  logic [CALW-1:0] cal_gain_i,
  output logic [DW-1:0]   data_q,
  output logic [CALW-1:0] offs_q,
  output logic [CALW-1:0] gain_q,
  output ctl_t            ctl_q,
  output logic            upd,
  output logic            mode_wr,
  output logic [1:0]      mode_val
);
  logic cmd_wr;

  assign cmd_wr   = wr_ok && (wr_addr == ADR_CMD);
  assign mode_val = wr_data[1:0];
  assign mode_wr  = cmd_wr && (wr_data[1:0] != MODE_RSVD);
  assign upd      = (wr_ok && wr_addr == ADR_DATA) || (cmd_wr && wr_data[B_CLR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      offs_q <= '0;
      gain_q <= '0;
      ctl_q  <= '0;
    end else if (cal_load) begin
      offs_q <= cal_offs_i;
      gain_q <= cal_gain_i;
    end else if (wr_ok) begin
      unique case (wr_addr)
        ADR_DATA: data_q <= wr_data[DW-1:0];
        ADR_OFFS: offs_q <= wr_data;
        ADR_GAIN: gain_q <= wr_data;
        default: begin
          ctl_q.fmt_bin     <= wr_data[B_FMT];
          ctl_q.no_fast     <= wr_data[B_NOFAST];
          ctl_q.always_fast <= wr_data[B_ALWAYS];
          ctl_q.cal_pin     <= wr_data[B_CALPIN];
          if (wr_data[B_CLR]) data_q <= '0;
          if (wr_data[B_CRST]) begin
            offs_q <= '0;
            gain_q <= '0;
          end
        end
      endcase
    end
  end

  p_crst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[B_CRST]) |=> (offs_q == '0 && gain_q == '0));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[B_CLR]) |=> (data_q == '0));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_load |=> (offs_q == $past(cal_offs_i) && gain_q == $past(cal_gain_i)));
endmodule

// File: rtl/dmc_outpath.sv
module dmc_outpath
  import dmc_pkg::*;
#(
  parameter int DW = 16,
  parameter int STEP_TH = 1049
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] data_q,
  input  ctl_t          ctl_q,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] code,
  output logic          fast
);
  localparam logic [DW-1:0] SIGN = {1'b1, {(DW-1){1'b0}}};

  logic          pend;
  logic          launch;
  logic [DW-1:0] last;
  logic [DW-1:0] nxt;
  logic [DW-1:0] step;
  logic          nxt_fast;

  assign launch = pend && (!valid || ready);

  generate
    if (DW > 1) begin : g_fmt
      assign nxt = ctl_q.fmt_bin ? data_q : (data_q ^ SIGN);
    end else begin : g_fmt1
      assign nxt = data_q;
    end
  endgenerate

  always_comb begin
    step     = (nxt > last) ? (nxt - last) : (last - nxt);
    nxt_fast = !ctl_q.no_fast && (ctl_q.always_fast || (step > DW'(STEP_TH)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      valid <= 1'b0;
      code  <= '0;
      fast  <= 1'b0;
      last  <= '0;
    end else begin
      pend <= upd || (pend && !launch);
      if (launch) begin
        valid <= 1'b1;
        code  <= nxt;
        fast  <= nxt_fast;
        last  <= nxt;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(code) && $stable(fast)));
  p_nofast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && ctl_q.no_fast) |=> !fast);
endmodule

// File: rtl/dac_mode_ctrl.sv
module dac_mode_ctrl
  import dmc_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CALW    = 24,
  parameter int CAL_CYC = 1000000,
  parameter int PWR_CYC = 16,
  parameter int STEP_TH = 1049
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [CALW-1:0] wr_data,
  input  logic            cal_done_i,
  input  logic [CALW-1:0] cal_offs_i,
  input  logic [CALW-1:0] cal_gain_i,
  output logic [15:0]     cmd_o,
  output logic [DW-1:0]   data_o,
  output logic [CALW-1:0] offs_o,
  output logic [CALW-1:0] gain_o,
  output logic            mod_valid_o,
  input  logic            mod_ready_i,
  output logic [DW-1:0]   mod_code_o,
  output logic            mod_fast_o,
  output logic            out_en_o,
  output logic            powering_o,
  output logic            cal_busy_o
);
  logic [1:0] mode_q;
  logic       wr_ok;
  logic       cal_load;
  logic       upd;
  logic       mode_wr;
  logic [1:0] mode_val;
  ctl_t       ctl_q;

  assign cal_busy_o = (mode_q == MODE_CAL);
  assign wr_ok      = wr_en && !cal_busy_o;
  assign cmd_o      = {8'h00, ctl_q.cal_pin, ctl_q.always_fast, ctl_q.no_fast,
                       2'b00, ctl_q.fmt_bin, mode_q};

  dmc_regs #(.DW(DW), .CALW(CALW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal_load(cal_load), .cal_offs_i(cal_offs_i), .cal_gain_i(cal_gain_i),
    .data_q(data_o), .offs_q(offs_o), .gain_q(gain_o), .ctl_q(ctl_q),
    .upd(upd), .mode_wr(mode_wr), .mode_val(mode_val)
  );

  dmc_seq #(.CAL_CYC(CAL_CYC), .PWR_CYC(PWR_CYC)) i_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .cal_done_i(cal_done_i), .cal_pin(ctl_q.cal_pin), .mode_q(mode_q),
    .cal_load(cal_load), .out_en(out_en_o), .powering(powering_o)
  );

  dmc_outpath #(.DW(DW), .STEP_TH(STEP_TH)) i_out (
    .clk(clk), .rst_n(rst_n), .upd(upd), .data_q(data_o), .ctl_q(ctl_q),
    .ready(mod_ready_i), .valid(mod_valid_o), .code(mod_code_o), .fast(mod_fast_o)
  );

  p_lock_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_o |=> $stable(data_o));
  p_lock_stream_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy_o && !mod_valid_o) |=> !mod_valid_o);
endmodule

// File: tb/test_dac_mode_ctrl.sv
module test_dac_mode_ctrl;
  localparam int CALC = 40;
  localparam int PWRC = 6;
  localparam int TH   = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [23:0] wr_data = 24'd0;
  logic        cal_done_i = 1'b0;
  logic [23:0] cal_offs_i = 24'h000000;
  logic [23:0] cal_gain_i = 24'h000000;
  logic        mod_ready_i = 1'b1;
  logic [15:0] cmd_o, data_o, mod_code_o;
  logic [23:0] offs_o, gain_o;
  logic        mod_valid_o, mod_fast_o, out_en_o, powering_o, cal_busy_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  dac_mode_ctrl #(.CAL_CYC(CALC), .PWR_CYC(PWRC), .STEP_TH(TH)) i_dac_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal_done_i(cal_done_i), .cal_offs_i(cal_offs_i), .cal_gain_i(cal_gain_i),
    .cmd_o(cmd_o), .data_o(data_o), .offs_o(offs_o), .gain_o(gain_o),
    .mod_valid_o(mod_valid_o), .mod_ready_i(mod_ready_i), .mod_code_o(mod_code_o),
    .mod_fast_o(mod_fast_o), .out_en_o(out_en_o), .powering_o(powering_o),
    .cal_busy_o(cal_busy_o)
  );

  always #2 clk = ~clk;

  // behavioural reference: state 0 sleep, 1 wake, 2 run, 3 cal
  int m_mode = 2, m_st = 0, m_cnt = 0;
  int m_data = 0, m_offs = 0, m_gain = 0;
  bit m_fmt = 0, m_nofast = 0, m_always = 0, m_calpin = 0;
  bit m_pend = 0, m_valid = 0, m_fast = 0;
  int m_code = 0, m_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 2; m_st = 0; m_cnt = 0; m_data = 0; m_offs = 0; m_gain = 0;
      m_fmt = 0; m_nofast = 0; m_always = 0; m_calpin = 0;
      m_pend = 0; m_valid = 0; m_fast = 0; m_code = 0; m_last = 0;
    end else begin
      bit ok, upd, fin, launch;
      int c, d, wm;
      ok = wr_en && (m_mode != 1);
      wm = int'(wr_data[1:0]);
      upd = ok && (wr_addr == 0 || (wr_addr == 1 && wr_data[3]));
      launch = m_pend && (!m_valid || mod_ready_i);
      if (launch) begin
        c = m_fmt ? m_data : (m_data ^ 32'h8000);
        d = (c > m_last) ? c - m_last : m_last - c;
        m_fast = !m_nofast && (m_always || d > TH);
        m_code = c; m_last = c; m_valid = 1;
      end else if (mod_ready_i) m_valid = 0;
      m_pend = upd || (m_pend && !launch);
      fin = (m_st == 3) && (m_cnt == CALC - 1 || cal_done_i);
      if (fin) begin m_offs = int'(cal_offs_i); m_gain = int'(cal_gain_i); end
      else if (ok) begin
        case (wr_addr)
          2'd0: m_data = int'(wr_data[15:0]);
          2'd2: m_offs = int'(wr_data);
          2'd3: m_gain = int'(wr_data);
          default: begin
            m_fmt = wr_data[2]; m_nofast = wr_data[5];
            m_always = wr_data[6]; m_calpin = wr_data[7];
            if (wr_data[3]) m_data = 0;
            if (wr_data[4]) begin m_offs = 0; m_gain = 0; end
          end
        endcase
      end
      if (ok && wr_addr == 1 && wm != 3) begin
        m_mode = wm;
        if (wm == 2) m_st = 0;
        else if (m_st == 0) begin m_st = 1; m_cnt = 0; end
        else if (m_st != 1) begin m_st = (wm == 1) ? 3 : 2; if (wm == 1) m_cnt = 0; end
      end else if (m_st == 1) begin
        if (m_cnt == PWRC - 1) begin m_st = (m_mode == 1) ? 3 : 2; m_cnt = 0; end
        else m_cnt++;
      end else if (m_st == 3) begin
        if (fin) begin m_st = 2; m_mode = 0; end else m_cnt++;
      end
    end
  end

  task automatic cmp(string what, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      cmp("mode/cmd", "R2", int'(cmd_o),
          (m_calpin << 7) | (m_always << 6) | (m_nofast << 5) | (m_fmt << 2) | m_mode);
      cmp("busy", "R2", int'(cal_busy_o), int'(m_mode == 1));
      cmp("data", "R4", int'(data_o), m_data);
      cmp("offset", "R3", int'(offs_o), m_offs);
      cmp("gain", "R5", int'(gain_o), m_gain);
      cmp("out_en", "R8", int'(out_en_o), int'(m_st == 2 || (m_st == 3 && m_calpin)));
      cmp("powering", "R9", int'(powering_o), int'(m_st == 1));
      cmp("valid", "R11", int'(mod_valid_o), int'(m_valid));
      if (m_valid) begin
        cmp("code", "R6", int'(mod_code_o), m_code);
        cmp("fast", "R7", int'(mod_fast_o), int'(m_fast));
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state checked directly
    cmp("reset cmd", "R1", int'(cmd_o), 32'h0002);
    cmp("reset valid", "R1", int'(mod_valid_o), 0);
    cmp("reset out_en", "R1", int'(out_en_o), 0);
    wr(2'd0, 24'h001234);            // data during sleep, R6 offset two's complement
    idle(2);
    wr(2'd1, 24'h000000);            // leave sleep, R9 wake-up
    idle(PWRC + 2);
    cmp("running", "R8", int'(out_en_o), 1);
    wr(2'd0, 24'h001234 + TH);       // exactly threshold: slow, R7
    idle(2);
    wr(2'd0, 24'h001234 + 2 * TH + 1); // above threshold: fast
    idle(2);
    wr(2'd1, 24'h000020);            // no-fast
    wr(2'd0, 24'h00F000);
    idle(2);
    wr(2'd1, 24'h000040);            // always-fast
    wr(2'd0, 24'h00F001);
    idle(2);
    wr(2'd1, 24'h000004);            // straight binary, R6
    wr(2'd0, 24'h00ABCD);
    idle(2);
    mod_ready_i = 1'b0;              // R11 stall and merge
    wr(2'd0, 24'h000111);
    wr(2'd0, 24'h000222);
    wr(2'd0, 24'h000333);
    idle(3);
    mod_ready_i = 1'b1;
    idle(4);
    wr(2'd1, 24'h00000F);            // R10 reserved mode, clear with fmt=1 (R4)
    idle(3);
    cmp("rsvd mode", "R10", int'(cmd_o[1:0]), 0);
    wr(2'd2, 24'h123456);
    wr(2'd3, 24'hABCDEF);
    wr(2'd1, 24'h000010);            // R5 calibration reset
    idle(2);
    cal_offs_i = 24'h0A0B0C; cal_gain_i = 24'hC0FFEE;
    wr(2'd1, 24'h000081);            // R2 calibration, connected
    wr(2'd0, 24'h005555);            // ignored
    wr(2'd2, 24'h111111);
    wr(2'd1, 24'h000002);
    idle(CALC + 4);
    cmp("cal end mode", "R2", int'(cmd_o[1:0]), 0);
    cmp("cal offset", "R3", int'(offs_o), 32'h0A0B0C);
    wr(2'd1, 24'h000002);            // to sleep
    idle(2);
    cal_offs_i = 24'h00F00D; cal_gain_i = 24'h00BEEF;
    wr(2'd1, 24'h000001);            // calibration from sleep: wake first, R9
    idle(PWRC + 5);
    @(negedge clk); cal_done_i = 1'b1;  // early finish, R3
    @(negedge clk); cal_done_i = 1'b0;
    idle(3);
    cmp("early gain", "R3", int'(gain_o), 32'h00BEEF);
    wr(2'd0, 24'h000000);
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule